// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block sits between a memory controller and a bank of memory devices. On each rising clock edge it captures the address/command bus and drives it out twice, as an A copy and a B copy. The address, bank address and the three command strobes only update in a cycle that carries exactly one active (low) chip select. When no select is low, or when several are low together, those outputs keep their earlier value. Clock-enable and termination-control lines bypass this gate and are captured on every edge.

A mode input picks between two and four usable chip selects. Each output copy has its own enable bit. When a copy is disabled, its valid flag drops and its data outputs read zero. Reset is active-low and sampled on the clock edge. While reset is held, both copies are disabled. After reset is released, both copies come back enabled but drive all zeros until the first qualified access has been captured.

Top module: `cmd_gate_reg`

## Requirements
- R1: In the cycle after an edge that samples `rst_n` low, `q_oe_a` and `q_oe_b` are 0 and every data output of both groups is 0.
- R2: After reset is released, each enabled group shows `q_oe` = 1 one cycle later. All of its data outputs, including `q_cs_n`, `q_cke` and `q_odt`, stay 0 until the first qualified access has been captured.
- R3: A qualified access is an edge at which exactly one effective chip select is low. Bit i of `cs_n_in` is chip select i. One cycle later, both groups show the address, bank address, command bits and effective chip-select vector sampled at that edge. Command bit 2 is RAS, bit 1 is CAS and bit 0 is WE.
- R4: At an edge with no effective chip select low, the address, bank address and command outputs keep their previous values. `q_cs_n` becomes all ones.
- R5: At an edge with two or more effective chip selects low, the address, bank address and command outputs keep their previous values. `q_cs_n` becomes all ones.
- R6: With `quad_en` = 0, the upper half of `cs_n_in` (bits 3 and 2) is treated as high. A lone low on bit 2 or 3 is not an access. A low on bit 0 together with a low on bit 2 is a qualified access on select 0, and `q_cs_n` shows bits 3:2 high.
- R7: With `quad_en` = 1, a lone low on chip select 2 or 3 is a qualified access and appears on `q_cs_n`.
- R8: Once primed, `q_cke` and `q_odt` show the `cke_in` and `odt_in` values from the previous edge, whatever the chip selects were.
- R9: `grp_en[0]` enables group A and `grp_en[1]` enables group B. A disabled group shows `q_oe` = 0 and zero on all its data outputs, while the other group is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| quad_en | input | 1 | 1 = four chip selects usable, 0 = only selects 0 and 1 |
| grp_en | input | 2 | Output group enables, bit 0 = A, bit 1 = B |
| cs_n_in | input | NUM_CS (4) | Active-low chip selects |
| addr_in | input | ADDR_W (16) | Address bits |
| ba_in | input | BA_W (3) | Bank address |
| ctl_n_in | input | 3 | {RAS, CAS, WE}, active low |
| cke_in | input | CKE_W (2) | Clock-enable lines, ungated |
| odt_in | input | CKE_W (2) | Termination-control lines, ungated |
| q_oe_a | output | 1 | Group A outputs driven |
| q_addr_a | output | ADDR_W | Group A address |
| q_ba_a | output | BA_W | Group A bank address |
| q_ctl_n_a | output | 3 | Group A command strobes |
| q_cs_n_a | output | NUM_CS | Group A chip selects |
| q_cke_a | output | CKE_W | Group A clock enables |
| q_odt_a | output | CKE_W | Group A termination control |
| q_oe_b | output | 1 | Group B outputs driven |
| q_addr_b | output | ADDR_W | Group B address |
| q_ba_b | output | BA_W | Group B bank address |
| q_ctl_n_b | output | 3 | Group B command strobes |
| q_cs_n_b | output | NUM_CS | Group B chip selects |
| q_cke_b | output | CKE_W | Group B clock enables |
| q_odt_b | output | CKE_W | Group B termination control |

## Verification
The main gating function is driven with four kinds of chip-select pattern. A single low select must load the bus. All-high must hold it. Two lows must hold it as well, which catches a gate that checks for "any low" rather than "exactly one low". A mixed low on one lower and one upper select is then applied under both mode settings. In two-select mode that pattern must load, and in four-select mode it must hold, so it shows whether the upper selects are masked. A lone upper select is tried in both modes. Each hold step also changes the address and command values, so a register that reloads when it should hold is caught.

// File: rtl/cgr_pkg.sv
// Package: shared constants for the chip-select gated command register.
// Assumes: command strobes are always three bits, ordered {RAS, CAS, WE}.
package cgr_pkg;
    localparam int CTL_W      = 3;
    localparam int NUM_GROUPS = 2;
    localparam int CTL_RAS    = 2;
    localparam int CTL_CAS    = 1;
    localparam int CTL_WE     = 0;
endpackage

// File: rtl/cgr_cs_qualify.sv
// Module: cgr_cs_qualify
// Masks the upper chip selects when four-select mode is off. Flags a
// qualified access when exactly one effective select is low.
// Assumes: NUM_CS is even; the upper half is the optional set.
module cgr_cs_qualify #(
    parameter int NUM_CS = 4
) (
    input  logic              quad_en,
    input  logic [NUM_CS-1:0] cs_n_in,
    output logic [NUM_CS-1:0] cs_eff,
    output logic              hit
);
    localparam int HALF  = NUM_CS / 2;
    localparam int CNT_W = $clog2(NUM_CS + 1);

    logic [CNT_W-1:0] low_cnt;

    // Force the optional selects high unless four-select mode is on.
    always_comb begin
        cs_eff = cs_n_in;
        if (!quad_en) begin
            cs_eff[NUM_CS-1:HALF] = '1;
        end
    end

    // Count active selects; exactly one means a qualified access.
    always_comb begin
        low_cnt = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            low_cnt = low_cnt + CNT_W'(!cs_eff[i]);
        end
        hit = (low_cnt == CNT_W'(1));
    end
endmodule

// File: rtl/cgr_capture.sv
// Module: cgr_capture
// Holds the single shared copy of the registered bus. Gated fields load only
// on a qualified access. Clock-enable and termination lines load on every edge.
// Assumes: synchronous active-low reset; hit and cs_eff come from the qualifier.
module cgr_capture
    import cgr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int CKE_W  = 2,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [NUM_CS-1:0] cs_eff,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [CTL_W-1:0]  ctl_n_in,
    input  logic [CKE_W-1:0]  cke_in,
    input  logic [CKE_W-1:0]  odt_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BA_W-1:0]   ba_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [NUM_CS-1:0] cs_q,
    output logic [CKE_W-1:0]  cke_q,
    output logic [CKE_W-1:0]  odt_q,
    output logic              primed_q,
    output logic              live_q
);
    // Gated fields: load on a qualified access, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            ba_q     <= '0;
            ctl_q    <= '0;
            primed_q <= 1'b0;
        end else if (hit) begin
            addr_q   <= addr_in;
            ba_q     <= ba_in;
            ctl_q    <= ctl_n_in;
            primed_q <= 1'b1;
        end
    end

    // Select copy: pass the qualifying pattern, otherwise deassert all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= hit ? cs_eff : '1;
        end
    end

    // Ungated lines and the output-live flag update on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= '0;
            odt_q  <= '0;
            live_q <= 1'b0;
        end else begin
            cke_q  <= cke_in;
            odt_q  <= odt_in;
            live_q <= 1'b1;
        end
    end

    // R3: a capture leaves exactly one select low in the held copy.
    assert_single_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ($countones(~cs_q) == 1));

    // R4 / R5: without a qualified access the gated fields do not move.
    assert_gated_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(addr_q) && $stable(ba_q) && $stable(ctl_q)));

    assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (cs_q == '1));

    // R8: ungated lines follow the inputs of the previous edge.
    assert_ungated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_q == $past(cke_in) && odt_q == $past(odt_in)));
endmodule

// File: rtl/cgr_out_group.sv
// Module: cgr_out_group
// Drives one output copy. Data reads zero when the copy is disabled or
// before the first qualified access.
// Assumes: inputs are registered values; this stage is pure gating.
module cgr_out_group
    import cgr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int CKE_W  = 2,
    parameter int NUM_CS = 4
) (
    input  logic              live,
    input  logic              enable,
    input  logic              primed,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [BA_W-1:0]   ba_q,
    input  logic [CTL_W-1:0]  ctl_q,
    input  logic [NUM_CS-1:0] cs_q,
    input  logic [CKE_W-1:0]  cke_q,
    input  logic [CKE_W-1:0]  odt_q,
    output logic              oe,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [NUM_CS-1:0] cs_o,
    output logic [CKE_W-1:0]  cke_o,
    output logic [CKE_W-1:0]  odt_o
);
    logic show;

    // Pass the registered bus only when the copy is enabled and primed.
    always_comb begin
        oe     = live && enable;
        show   = oe && primed;
        addr_o = show ? addr_q : '0;
        ba_o   = show ? ba_q   : '0;
        ctl_o  = show ? ctl_q  : '0;
        cs_o   = show ? cs_q   : '0;
        cke_o  = show ? cke_q  : '0;
        odt_o  = show ? odt_q  : '0;
    end
endmodule

// File: rtl/cmd_gate_reg.sv
// Module: cmd_gate_reg (top)
// Chip-select gated command register with two output copies. It qualifies
// the selects, captures one shared copy and fans it out to groups A and B.
// Assumes: synchronous active-low reset; one cycle from input to output.
module cmd_gate_reg
    import cgr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int CKE_W  = 2,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_en,
    input  logic [1:0]        grp_en,
    input  logic [NUM_CS-1:0] cs_n_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [2:0]        ctl_n_in,
    input  logic [CKE_W-1:0]  cke_in,
    input  logic [CKE_W-1:0]  odt_in,
    output logic              q_oe_a,
    output logic [ADDR_W-1:0] q_addr_a,
    output logic [BA_W-1:0]   q_ba_a,
    output logic [2:0]        q_ctl_n_a,
    output logic [NUM_CS-1:0] q_cs_n_a,
    output logic [CKE_W-1:0]  q_cke_a,
    output logic [CKE_W-1:0]  q_odt_a,
    output logic              q_oe_b,
    output logic [ADDR_W-1:0] q_addr_b,
    output logic [BA_W-1:0]   q_ba_b,
    output logic [2:0]        q_ctl_n_b,
    output logic [NUM_CS-1:0] q_cs_n_b,
    output logic [CKE_W-1:0]  q_cke_b,
    output logic [CKE_W-1:0]  q_odt_b
);
    localparam int HALF = NUM_CS / 2;

    logic [NUM_CS-1:0] cs_eff;
    logic              hit;
    logic [ADDR_W-1:0] addr_q;
    logic [BA_W-1:0]   ba_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [NUM_CS-1:0] cs_q;
    logic [CKE_W-1:0]  cke_q;
    logic [CKE_W-1:0]  odt_q;
    logic              primed_q;
    logic              live_q;

    logic              g_oe   [NUM_GROUPS];
    logic [ADDR_W-1:0] g_addr [NUM_GROUPS];
    logic [BA_W-1:0]   g_ba   [NUM_GROUPS];
    logic [CTL_W-1:0]  g_ctl  [NUM_GROUPS];
    logic [NUM_CS-1:0] g_cs   [NUM_GROUPS];
    logic [CKE_W-1:0]  g_cke  [NUM_GROUPS];
    logic [CKE_W-1:0]  g_odt  [NUM_GROUPS];

    cgr_cs_qualify #(.NUM_CS(NUM_CS)) u_qual (
        .quad_en (quad_en),
        .cs_n_in (cs_n_in),
        .cs_eff  (cs_eff),
        .hit     (hit)
    );

    cgr_capture #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CKE_W(CKE_W), .NUM_CS(NUM_CS)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .cs_eff   (cs_eff),
        .addr_in  (addr_in),
        .ba_in    (ba_in),
        .ctl_n_in (ctl_n_in),
        .cke_in   (cke_in),
        .odt_in   (odt_in),
        .addr_q   (addr_q),
        .ba_q     (ba_q),
        .ctl_q    (ctl_q),
        .cs_q     (cs_q),
        .cke_q    (cke_q),
        .odt_q    (odt_q),
        .primed_q (primed_q),
        .live_q   (live_q)
    );

    // One output stage per copy, each with its own enable bit.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
        cgr_out_group #(
            .ADDR_W(ADDR_W), .BA_W(BA_W), .CKE_W(CKE_W), .NUM_CS(NUM_CS)
        ) u_grp (
            .live   (live_q),
            .enable (grp_en[g]),
            .primed (primed_q),
            .addr_q (addr_q),
            .ba_q   (ba_q),
            .ctl_q  (ctl_q),
            .cs_q   (cs_q),
            .cke_q  (cke_q),
            .odt_q  (odt_q),
            .oe     (g_oe[g]),
            .addr_o (g_addr[g]),
            .ba_o   (g_ba[g]),
            .ctl_o  (g_ctl[g]),
            .cs_o   (g_cs[g]),
            .cke_o  (g_cke[g]),
            .odt_o  (g_odt[g])
        );
    end

    // Map the group array onto the named A and B ports.
    always_comb begin
        q_oe_a    = g_oe[0];
        q_addr_a  = g_addr[0];
        q_ba_a    = g_ba[0];
        q_ctl_n_a = g_ctl[0];
        q_cs_n_a  = g_cs[0];
        q_cke_a   = g_cke[0];
        q_odt_a   = g_odt[0];
        q_oe_b    = g_oe[1];
        q_addr_b  = g_addr[1];
        q_ba_b    = g_ba[1];
        q_ctl_n_b = g_ctl[1];
        q_cs_n_b  = g_cs[1];
        q_cke_b   = g_cke[1];
        q_odt_b   = g_odt[1];
    end

    // R1: a sampled reset disables both copies on the next cycle.
    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> (!q_oe_a && !q_oe_b && q_addr_a == '0 && q_addr_b == '0));

    // R2: before the first capture, the driven outputs stay low.
    assert_prime_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |-> (q_addr_a == '0 && q_cs_n_a == '0 && q_cke_a == '0
                       && q_odt_b == '0 && q_cs_n_b == '0));

    // R6: in two-select mode the upper selects never appear low.
    assert_dual_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_en |=> (cs_q[NUM_CS-1:HALF] == '1));

    // R9: a disabled group is not driven.
    assert_group_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en[1] |-> (!q_oe_b && q_addr_b == '0 && q_cke_b == '0));
endmodule

// File: tb/tb_cmd_gate_reg.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. A step drives at a falling edge and
// checks both groups at the next falling edge against a behavioural model.
module tb_cmd_gate_reg;
    localparam int ADDR_W = 16;
    localparam int BA_W   = 3;
    localparam int CKE_W  = 2;
    localparam int NUM_CS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              quad_en = 1'b1;
    logic [1:0]        grp_en = 2'b11;
    logic [NUM_CS-1:0] cs_n_in = '1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [BA_W-1:0]   ba_in = '0;
    logic [2:0]        ctl_n_in = '0;
    logic [CKE_W-1:0]  cke_in = '0;
    logic [CKE_W-1:0]  odt_in = '0;
    logic              q_oe_a, q_oe_b;
    logic [ADDR_W-1:0] q_addr_a, q_addr_b;
    logic [BA_W-1:0]   q_ba_a, q_ba_b;
    logic [2:0]        q_ctl_n_a, q_ctl_n_b;
    logic [NUM_CS-1:0] q_cs_n_a, q_cs_n_b;
    logic [CKE_W-1:0]  q_cke_a, q_cke_b, q_odt_a, q_odt_b;

    int vectors = 0;
    int misses  = 0;

    // Model state
    logic              m_live = 1'b0, m_primed = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [BA_W-1:0]   m_ba = '0;
    logic [2:0]        m_ctl = '0;
    logic [NUM_CS-1:0] m_cs = '0;
    logic [CKE_W-1:0]  m_cke = '0, m_odt = '0;

    cmd_gate_reg dut (
        .clk(clk), .rst_n(rst_n), .quad_en(quad_en), .grp_en(grp_en),
        .cs_n_in(cs_n_in), .addr_in(addr_in), .ba_in(ba_in),
        .ctl_n_in(ctl_n_in), .cke_in(cke_in), .odt_in(odt_in),
        .q_oe_a(q_oe_a), .q_addr_a(q_addr_a), .q_ba_a(q_ba_a),
        .q_ctl_n_a(q_ctl_n_a), .q_cs_n_a(q_cs_n_a), .q_cke_a(q_cke_a),
        .q_odt_a(q_odt_a),
        .q_oe_b(q_oe_b), .q_addr_b(q_addr_b), .q_ba_b(q_ba_b),
        .q_ctl_n_b(q_ctl_n_b), .q_cs_n_b(q_cs_n_b), .q_cke_b(q_cke_b),
        .q_odt_b(q_odt_b)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, update the model, check a cycle on.
    task automatic step(string tag, logic [NUM_CS-1:0] cs, logic [ADDR_W-1:0] a,
                        logic [BA_W-1:0] b, logic [2:0] c,
                        logic [CKE_W-1:0] k, logic [CKE_W-1:0] o);
        logic [NUM_CS-1:0] eff;
        int lows;
        logic ena, shw;
        cs_n_in = cs; addr_in = a; ba_in = b; ctl_n_in = c; cke_in = k; odt_in = o;
        if (!rst_n) begin
            m_live = 0; m_primed = 0; m_addr = '0; m_ba = '0; m_ctl = '0;
            m_cs = '0; m_cke = '0; m_odt = '0;
        end else begin
            eff = cs;
            if (!quad_en) eff[3:2] = 2'b11;
            lows = 0;
            for (int i = 0; i < NUM_CS; i++) if (!eff[i]) lows++;
            m_live = 1; m_cke = k; m_odt = o;
            if (lows == 1) begin
                m_addr = a; m_ba = b; m_ctl = c; m_cs = eff; m_primed = 1;
            end else begin
                m_cs = '1;
            end
        end
        @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            ena = m_live && grp_en[g];
            shw = ena && m_primed;
            chk(tag, g == 0 ? "oe_a" : "oe_b", 32'(g == 0 ? q_oe_a : q_oe_b), 32'(ena));
            chk(tag, g == 0 ? "addr_a" : "addr_b", 32'(g == 0 ? q_addr_a : q_addr_b),
                shw ? 32'(m_addr) : 32'd0);
            chk(tag, g == 0 ? "ba_a" : "ba_b", 32'(g == 0 ? q_ba_a : q_ba_b),
                shw ? 32'(m_ba) : 32'd0);
            chk(tag, g == 0 ? "ctl_a" : "ctl_b", 32'(g == 0 ? q_ctl_n_a : q_ctl_n_b),
                shw ? 32'(m_ctl) : 32'd0);
            chk(tag, g == 0 ? "cs_a" : "cs_b", 32'(g == 0 ? q_cs_n_a : q_cs_n_b),
                shw ? 32'(m_cs) : 32'd0);
            chk(tag, g == 0 ? "cke_a" : "cke_b", 32'(g == 0 ? q_cke_a : q_cke_b),
                shw ? 32'(m_cke) : 32'd0);
            chk(tag, g == 0 ? "odt_a" : "odt_b", 32'(g == 0 ? q_odt_a : q_odt_b),
                shw ? 32'(m_odt) : 32'd0);
        end
    endtask

    // R1: reset held with a valid-looking access still keeps outputs off.
    task automatic t_reset();
        rst_n = 0;
        step("R1", 4'b1110, 16'hBEEF, 3'd5, 3'b010, 2'b11, 2'b11);
        step("R1", 4'b1101, 16'h1234, 3'd2, 3'b101, 2'b01, 2'b10);
    endtask

    // R2: after release, driven but low until the first access.
    task automatic t_prime();
        rst_n = 1;
        step("R2", 4'b1111, 16'hAAAA, 3'd7, 3'b111, 2'b11, 2'b11);
        step("R2", 4'b1100, 16'h5555, 3'd1, 3'b001, 2'b10, 2'b01);
    endtask

    // R3: single-select captures, including the command bit order.
    task automatic t_single();
        step("R3", 4'b1110, 16'h1357, 3'd3, 3'b011, 2'b01, 2'b00);
        step("R3", 4'b1101, 16'h2468, 3'd6, 3'b100, 2'b10, 2'b11);
    endtask

    // R4: no select low -> gated hold, select copy all high.
    task automatic t_none();
        step("R4", 4'b1111, 16'hFFFF, 3'd0, 3'b111, 2'b11, 2'b01);
        step("R4", 4'b1111, 16'h0F0F, 3'd1, 3'b000, 2'b00, 2'b10);
    endtask

    // R5: several selects low -> gated hold.
    task automatic t_multi();
        step("R5", 4'b1100, 16'hC0DE, 3'd4, 3'b110, 2'b01, 2'b01);
        step("R5", 4'b0000, 16'hD00D, 3'd5, 3'b001, 2'b10, 2'b00);
    endtask

    // R8: ungated lines track every edge regardless of selects.
    task automatic t_ungated();
        step("R8", 4'b1111, 16'h0001, 3'd0, 3'b000, 2'b10, 2'b01);
        step("R8", 4'b0011, 16'h0002, 3'd1, 3'b001, 2'b01, 2'b10);
    endtask

    // R6 and R7: upper selects masked in two-select mode, usable in four.
    task automatic t_modes();
        quad_en = 0;
        step("R6", 4'b1011, 16'h7777, 3'd7, 3'b010, 2'b00, 2'b00);
        step("R6", 4'b1010, 16'h8181, 3'd2, 3'b101, 2'b11, 2'b00);
        quad_en = 1;
        step("R7", 4'b1010, 16'h9292, 3'd3, 3'b110, 2'b11, 2'b11);
        step("R7", 4'b0111, 16'hA3A3, 3'd4, 3'b011, 2'b01, 2'b01);
        step("R7", 4'b1011, 16'hB4B4, 3'd1, 3'b100, 2'b10, 2'b10);
    endtask

    // R9: per-group enables act independently.
    task automatic t_groups();
        grp_en = 2'b01;
        step("R9", 4'b1110, 16'hC5C5, 3'd6, 3'b001, 2'b11, 2'b01);
        grp_en = 2'b10;
        step("R9", 4'b1101, 16'hD6D6, 3'd2, 3'b010, 2'b01, 2'b11);
        grp_en = 2'b00;
        step("R9", 4'b1111, 16'hE7E7, 3'd3, 3'b111, 2'b10, 2'b10);
        grp_en = 2'b11;
        step("R9", 4'b1111, 16'hF8F8, 3'd0, 3'b000, 2'b00, 2'b01);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_prime();
        t_single();
        t_none();
        t_multi();
        t_ungated();
        t_modes();
        t_groups();
        t_reset();
        t_prime();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule